// File: doc/BRIEF.md
# Tagged-Error Serial Receiver

This block recovers asynchronous serial characters from a single input line and queues each one with its own error tags. An external pulse, one clock wide and arriving sixteen times per bit period, paces all sampling. A line-control byte selects the frame shape: five to eight data bits sent least significant bit first, an optional parity bit with odd or even sense, and one or two stop bits. The same byte also turns the queue on or off. Characters are accepted only while both the global enable and the receive enable are high.

Each stored entry holds the character and four tags: framing, parity, break and overrun. The entry leaves through a valid/ready read stream. `rd_valid` is high whenever at least one entry is stored, and `rd_data` shows the oldest entry. An entry is removed on a clock edge where `rd_valid` and `rd_ready` are both high. While the consumer holds `rd_ready` low, the head entry stays put. Its character, framing, parity and break fields do not change. Its overrun tag can still be set, if that entry is also the newest one and another character is lost. The receiver never waits for the reader. When the queue is full, the new character is dropped and the loss is recorded on the newest stored entry. A status byte reports whether the queue is empty or full.

Top module: `uart_rxt_top`

## Requirements
- R1: `rd_data` packs an entry as follows: character in bits 7:0, framing error in bit 8, parity error in bit 9, break in bit 10, overrun in bit 11. Data bits above the configured word length read as zero.
- R2: `line_ctrl[6:5]` sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits are received least significant first.
- R3: When `line_ctrl[1]` is 1, a parity bit follows the data. `line_ctrl[2]` = 1 selects even parity and 0 selects odd. A mismatch sets bit 9 of the entry. When `line_ctrl[1]` is 0, no parity bit is expected and bit 9 is always 0.
- R4: `line_ctrl[3]` = 1 selects two stop bits. A stop bit sampled low sets the framing bit (bit 8), and the character is still stored.
- R5: A frame that is low from the start bit through the first stop bit is stored as one entry: character 0 with both break and framing set. A new character is looked for only after the line has returned high.
- R6: A falling edge is confirmed at the middle of the start bit. If the line is high again at that point, no character is stored.
- R7: The queue holds DEPTH entries (16 by default). `rx_status[4]` is 1 when the queue is empty, and `rx_status[6]` is 1 when it is full. All other status bits read 0.
- R8: A character that arrives while the queue is full is discarded, and the overrun bit (bit 11) of the newest stored entry is set.
- R9: When `line_ctrl[4]` is 0, the queue acts as a single holding entry and reports full after one character.
- R10: Characters are received only while `uart_en` and `rx_en` are both 1. Otherwise the line is ignored.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and bits 10:0 of `rd_data` stay stable.
- R12: After reset the queue is empty: `rd_valid` is 0, `rx_status[4]` is 1 and `rx_status[6]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling pulse, 16 per bit period |
| rxd | input | 1 | Serial input line, idle high |
| line_ctrl | input | 8 | Frame format and queue enable |
| uart_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| rd_valid | output | 1 | Queue holds an entry |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_data | output | 12 | Head entry: character and error tags |
| rx_status | output | 8 | Bit 4 queue empty, bit 6 queue full |

## Verification
Clean 8-bit and 5-bit frames with asymmetric bit values show whether bit order and word-length masking are right. Frames with correct and with inverted parity, in both even and odd sense, separate the parity sense from the enable. Frames with a low first or second stop bit, a line held low for a whole frame, and a short low glitch separate framing errors, breaks and rejected starts. Filling the queue past its depth, repeating that in single-entry mode, and sending while either enable is low show where overrun tags land and that disabled input is ignored.

// File: rtl/uart_rxt_pkg.sv
package uart_rxt_pkg;

  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par_err;
    logic       frm_err;
    logic [7:0] chr;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_HOLD
  } rx_state_t;

  localparam int STAT_EMPTY_BIT = 4;
  localparam int STAT_FULL_BIT  = 6;
  localparam int ENTRY_W        = $bits(rx_entry_t);

endpackage

// File: rtl/uart_rxt_sync.sv
module uart_rxt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rxt_deframer.sv
module uart_rxt_deframer
  import uart_rxt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      os_tick,
  input  logic      rx_in,
  input  logic      active,
  input  logic [7:0] lcr,
  output logic      push,
  output rx_entry_t push_word
);
  rx_state_t  state;
  logic [3:0] tcnt;
  logic [2:0] bidx;
  logic [7:0] shreg;
  logic       par_acc;
  logic       par_bit;
  logic       all_zero;

  logic [2:0] last_idx;
  logic       pen, even_sel, two_stop, mid, pe_calc;

  assign last_idx = 3'(lcr[6:5]) + 3'd4;
  assign pen      = lcr[1];
  assign even_sel = lcr[2];
  assign two_stop = lcr[3];
  assign mid      = os_tick && (tcnt == 4'd15);
  assign pe_calc  = pen && (even_sel ? (par_acc ^ par_bit) : ~(par_acc ^ par_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      par_bit   <= 1'b0;
      all_zero  <= 1'b0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      push <= 1'b0;
      if (!active) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (os_tick && !rx_in) begin
              state <= ST_START;
              tcnt  <= '0;
            end
          end
          ST_START: begin
            if (os_tick) begin
              if (tcnt == 4'd7) begin
                if (rx_in) begin
                  state <= ST_IDLE;
                end else begin
                  state    <= ST_DATA;
                  tcnt     <= '0;
                  bidx     <= '0;
                  shreg    <= '0;
                  par_acc  <= 1'b0;
                  par_bit  <= 1'b0;
                  all_zero <= 1'b1;
                end
              end else begin
                tcnt <= tcnt + 4'd1;
              end
            end
          end
          ST_DATA: begin
            if (os_tick) tcnt <= tcnt + 4'd1;
            if (mid) begin
              shreg[bidx] <= rx_in;
              par_acc     <= par_acc ^ rx_in;
              if (rx_in) all_zero <= 1'b0;
              if (bidx == last_idx) state <= pen ? ST_PAR : ST_STOP1;
              else                  bidx  <= bidx + 3'd1;
            end
          end
          ST_PAR: begin
            if (os_tick) tcnt <= tcnt + 4'd1;
            if (mid) begin
              par_bit <= rx_in;
              if (rx_in) all_zero <= 1'b0;
              state <= ST_STOP1;
            end
          end
          ST_STOP1: begin
            if (os_tick) tcnt <= tcnt + 4'd1;
            if (mid) begin
              if (!rx_in) begin
                push              <= 1'b1;
                push_word.ovr     <= 1'b0;
                push_word.brk     <= all_zero;
                push_word.par_err <= all_zero ? 1'b0 : pe_calc;
                push_word.frm_err <= 1'b1;
                push_word.chr     <= shreg;
                state             <= ST_HOLD;
              end else if (two_stop) begin
                state <= ST_STOP2;
              end else begin
                push              <= 1'b1;
                push_word.ovr     <= 1'b0;
                push_word.brk     <= 1'b0;
                push_word.par_err <= pe_calc;
                push_word.frm_err <= 1'b0;
                push_word.chr     <= shreg;
                state             <= ST_IDLE;
              end
            end
          end
          ST_STOP2: begin
            if (os_tick) tcnt <= tcnt + 4'd1;
            if (mid) begin
              push              <= 1'b1;
              push_word.ovr     <= 1'b0;
              push_word.brk     <= 1'b0;
              push_word.par_err <= pe_calc;
              push_word.frm_err <= ~rx_in;
              push_word.chr     <= shreg;
              state             <= rx_in ? ST_IDLE : ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (rx_in) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: a break entry always carries character zero and the framing tag
  a_r5_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    push && push_word.brk |-> (push_word.chr == 8'h00) && push_word.frm_err);

  // R10: when reception is off the machine returns to idle and stores nothing
  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state == ST_IDLE) && !push);

  // R6: a rejected start produces no store on the following cycle
  a_r6_glitch_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) && os_tick && (tcnt == 4'd7) && rx_in |=> !push);

  // R4: without a parity or stop step a store never fires from the data phase
  a_r4_push_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($past(state) == ST_STOP1) || ($past(state) == ST_STOP2));
endmodule

// File: rtl/uart_rxt_fifo.sv
module uart_rxt_fifo
  import uart_rxt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en,
  input  logic      wr_en,
  input  rx_entry_t wr_word,
  input  logic      rd_ready,
  output logic      rd_valid,
  output rx_entry_t rd_word,
  output logic      empty,
  output logic      full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [CNT_W-1:0] count, limit;
  logic             do_push, do_pop, do_mark;

  assign limit    = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (count >= limit);
  assign empty    = (count == '0);
  assign rd_valid = !empty;
  assign rd_word  = mem[rd_ptr];
  assign do_push  = wr_en && !full;
  assign do_mark  = wr_en && full && !empty;
  assign do_pop   = rd_valid && rd_ready;
  assign last_ptr = wr_ptr - PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)      mem[wr_ptr]     <= wr_word;
    else if (do_mark) mem[last_ptr].ovr <= 1'b1;
  end

  // R7: occupancy never exceeds the configured depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R8: a store into a full queue leaves the occupancy unchanged
  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && full && !do_pop |=> count == $past(count));

  // R9: in single-entry mode at most one entry is held after a store
  a_r9_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && $past(!fifo_en) && (count <= CNT_W'(1)) |=> (count <= CNT_W'(1)) || fifo_en);

  // R11: a stalled head keeps its character and non-overrun tags
  a_r11_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_word.chr) && $stable(rd_word.frm_err)
                                && $stable(rd_word.par_err) && $stable(rd_word.brk));
endmodule

// File: rtl/uart_rxt_top.sv
module uart_rxt_top
  import uart_rxt_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rxd,
  input  logic [7:0]  line_ctrl,
  input  logic        uart_en,
  input  logic        rx_en,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [11:0] rd_data,
  output logic [7:0]  rx_status
);
  logic      rx_s, active, push, q_empty, q_full;
  rx_entry_t push_word, head;

  assign active = uart_en && rx_en;

  uart_rxt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_in(rxd), .d_out(rx_s)
  );

  uart_rxt_deframer i_deframer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_s),
    .active(active), .lcr(line_ctrl), .push(push), .push_word(push_word)
  );

  uart_rxt_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(line_ctrl[4]),
    .wr_en(push), .wr_word(push_word),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_word(head),
    .empty(q_empty), .full(q_full)
  );

  assign rd_data = head;

  always_comb begin
    rx_status                 = '0;
    rx_status[STAT_EMPTY_BIT] = q_empty;
    rx_status[STAT_FULL_BIT]  = q_full;
  end

  // R12 / R7: a valid head and the empty flag never coexist
  a_r7_valid_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !rx_status[STAT_EMPTY_BIT]);
endmodule

// File: tb/test_uart_rxt_top.sv
module test_uart_rxt_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BT         = 16 * TDIV;
  localparam int DEPTH      = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        os_tick = 0;
  logic        rxd = 1;
  logic [7:0]  line_ctrl = 8'h70;
  logic        uart_en = 1, rx_en = 1;
  logic        rd_valid, rd_ready = 0;
  logic [11:0] rd_data;
  logic [7:0]  rx_status;

  int n_chk = 0, n_bad = 0;

  uart_rxt_top #(.DEPTH(DEPTH)) i_uart_rxt_top (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .line_ctrl(line_ctrl),
    .uart_en(uart_en), .rx_en(rx_en), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rx_status(rx_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      os_tick = 1;
      @(negedge clk);
      os_tick = 0;
    end
  end

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bits_time(input int n);
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen, input bit even,
                            input bit flip, input bit s1, input bit two, input bit s2);
    logic p;
    p = 0;
    @(negedge clk);
    rxd = 0; bits_time(1);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; p = p ^ d[i]; bits_time(1);
    end
    if (pen) begin
      rxd = (even ? p : ~p) ^ flip; bits_time(1);
    end
    rxd = s1; bits_time(1);
    if (two) begin rxd = s2; bits_time(1); end
    rxd = 1; bits_time(2);
  endtask

  task automatic send8(input logic [7:0] d);
    send_frame(d, 8, 0, 0, 0, 1, 0, 1);
  endtask

  task automatic get_word(input string req, output logic [11:0] w);
    int t;
    t = 0;
    while (!rd_valid && t < 4000) begin @(negedge clk); t++; end
    w = rd_data;
    if (!rd_valid) begin
      n_chk++; n_bad++;
      $display("FAIL %s: actual no-valid expected valid", req);
    end
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic expect_word(input string req, input logic [11:0] exp);
    logic [11:0] w;
    get_word(req, w);
    check(req, w, exp);
  endtask

  task automatic t_reset();
    check("R12 valid", {11'b0, rd_valid}, 12'h0);
    check("R12 status", {4'b0, rx_status}, 12'h010);
  endtask

  task automatic t_basic();
    line_ctrl = 8'h70;
    send8(8'hA5);
    send8(8'h3C);
    expect_word("R1 R2 8-bit first", 12'h0A5);
    expect_word("R1 R2 8-bit second", 12'h03C);
    check("R7 empty after drain", {4'b0, rx_status}, 12'h010);
  endtask

  task automatic t_word5();
    line_ctrl = 8'h10;
    send_frame(8'hF3, 5, 0, 0, 0, 1, 0, 1);
    expect_word("R2 5-bit masked", 12'h013);
    line_ctrl = 8'h30;
    send_frame(8'h6A, 6, 0, 0, 0, 1, 0, 1);
    expect_word("R2 6-bit masked", 12'h02A);
  endtask

  task automatic t_parity();
    line_ctrl = 8'h76;
    send_frame(8'h55, 8, 1, 1, 0, 1, 0, 1);
    expect_word("R3 even good", 12'h055);
    send_frame(8'h55, 8, 1, 1, 1, 1, 0, 1);
    expect_word("R3 even bad", 12'h255);
    line_ctrl = 8'h72;
    send_frame(8'h07, 8, 1, 0, 0, 1, 0, 1);
    expect_word("R3 odd good", 12'h007);
    send_frame(8'h07, 8, 1, 0, 1, 1, 0, 1);
    expect_word("R3 odd bad", 12'h207);
  endtask

  task automatic t_stop();
    line_ctrl = 8'h78;
    send_frame(8'h81, 8, 0, 0, 0, 1, 1, 1);
    expect_word("R4 two stops good", 12'h081);
    send_frame(8'h81, 8, 0, 0, 0, 1, 1, 0);
    expect_word("R4 second stop low", 12'h181);
    line_ctrl = 8'h70;
    send_frame(8'h42, 8, 0, 0, 0, 0, 0, 1);
    expect_word("R4 first stop low", 12'h142);
  endtask

  task automatic t_break();
    line_ctrl = 8'h70;
    @(negedge clk);
    rxd = 0; bits_time(12);
    rxd = 1; bits_time(2);
    expect_word("R5 break entry", 12'h500);
    check("R5 single entry", {11'b0, rd_valid}, 12'h0);
    send8(8'h5A);
    expect_word("R5 recovers", 12'h05A);
  endtask

  task automatic t_noise();
    line_ctrl = 8'h70;
    @(negedge clk);
    rxd = 0; repeat (3 * TDIV) @(negedge clk);
    rxd = 1; bits_time(12);
    check("R6 glitch ignored", {4'b0, rx_status}, 12'h010);
  endtask

  task automatic t_overrun();
    line_ctrl = 8'h70;
    for (int i = 0; i < DEPTH; i++) send8(8'(i + 8'h20));
    check("R7 full flag", {4'b0, rx_status}, 12'h040);
    send8(8'hEE);
    for (int i = 0; i < DEPTH; i++)
      expect_word("R8 overrun tag", (i == DEPTH - 1) ? 12'h800 | 12'(i + 8'h20) : 12'(i + 8'h20));
    check("R8 dropped char", {4'b0, rx_status}, 12'h010);
  endtask

  task automatic t_nofifo();
    line_ctrl = 8'h60;
    send8(8'h11);
    check("R9 full at one", {4'b0, rx_status}, 12'h040);
    send8(8'h22);
    expect_word("R9 held with overrun", 12'h811);
    check("R9 empty after", {4'b0, rx_status}, 12'h010);
  endtask

  task automatic t_disable();
    line_ctrl = 8'h70;
    rx_en = 0;
    send8(8'h99);
    check("R10 rx_en low", {4'b0, rx_status}, 12'h010);
    rx_en = 1; uart_en = 0;
    send8(8'h98);
    check("R10 uart_en low", {4'b0, rx_status}, 12'h010);
    uart_en = 1;
    send8(8'h97);
    expect_word("R10 re-enabled", 12'h097);
  endtask

  task automatic t_stall();
    logic [11:0] first;
    line_ctrl = 8'h70;
    send8(8'hC3);
    first = rd_data;
    repeat (20) @(negedge clk);
    check("R11 valid held", {11'b0, rd_valid}, 12'h001);
    check("R11 data held", rd_data, first);
    expect_word("R11 stalled entry", 12'h0C3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_word5();
    t_parity();
    t_stop();
    t_break();
    t_noise();
    t_overrun();
    t_nofifo();
    t_disable();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule